// File: doc/BRIEF.md
# Destructive-Read Multi-Select Word Store

This block is a small register file whose words behave like word-line-organised destructive storage. Each word has its own read-select line and its own write-select line, and one shared data bus carries the bit pattern. Reading a word returns its contents and clears it in the same operation. A caller that wants to keep the value must write it back.

A write can only set bits. Each selected word takes the bitwise OR of its old contents and the data bus. To store an exact value, the caller first clears the word, either with a read or with a clear. In clear mode, any number of read selects may be active together, and every selected word is emptied in one cycle with no sense data returned. A write may also select several words, so one data value can be spread over many words in a single cycle.

Malformed requests leave the storage untouched and raise a one-cycle error pulse. Two cases count as malformed: more than one read select outside clear mode, and read and write selects active in the same cycle. All outputs are registered and belong to the request presented one cycle earlier.

Top module: `wordline_store`

## Requirements
- R1: After reset every word holds zero, and `sense_q`, `sense_vld`, `err_multi` and `err_conflict` are all zero.
- R2: A read has exactly one `rd_sel` bit set, `clear_mode` low and `wr_sel` all zero. One cycle after it, `sense_q` holds the former contents of the selected word and `sense_vld` is 1.
- R3: A read leaves the selected word at zero, so an immediate second read of that word returns zero. Other words are unchanged.
- R4: With `clear_mode` high, `wr_sel` zero and any nonzero `rd_sel` mask, every selected word becomes zero and unselected words are kept. In the next cycle `sense_vld` is 0 and `sense_q` is 0.
- R5: A write has nonzero `wr_sel` and zero `rd_sel`. Every word whose `wr_sel` bit is 1 takes its old value OR `wr_data`, and other words are unchanged.
- R6: A write never clears a bit. Writing data B over a word holding A leaves A|B.
- R7: Two or more `rd_sel` bits with `clear_mode` low and zero `wr_sel` make `err_multi` 1 in the next cycle, with `sense_q` 0 and `sense_vld` 0. No word changes.
- R8: Nonzero `rd_sel` together with nonzero `wr_sel` makes `err_conflict` 1 in the next cycle, with `sense_vld` 0 and `sense_q` 0. No word changes, whatever the state of `clear_mode`.
- R9: With both select vectors zero, all four outputs are 0 in the next cycle and no word changes.
- R10: The two error flags never rise together, and each is high only in the cycle after an offending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_sel | input | WORDS | Per-word read/clear select |
| clear_mode | input | 1 | 1: read selects clear words without sensing |
| wr_sel | input | WORDS | Per-word write select |
| wr_data | input | BITS | Bits to set in the write-selected words |
| sense_q | output | BITS | Former contents of the word read in the previous cycle |
| sense_vld | output | 1 | `sense_q` carries read data |
| err_multi | output | 1 | Previous request had several read selects outside clear mode |
| err_conflict | output | 1 | Previous request mixed read and write selects |

## Verification
The bench works with four words of four bits and tries every data value in every word. Each value is read twice, which separates "returns the contents" from "clears on read". Every write-select mask is tried over a preloaded background, which shows that a write ORs into exactly the selected words and never clears a bit. Every clear mask and every multi-bit read mask is then applied over a known distinct pattern, followed by read-out of all words. This shows whether each request emptied exactly the selected words or, when rejected, left them all intact. Conflicting read/write mask pairs are checked the same way, with clear mode both low and high.

// File: rtl/wordline_store.sv
module wordline_store #(
  parameter int WORDS = 16,
  parameter int BITS  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WORDS-1:0] rd_sel,
  input  logic             clear_mode,
  input  logic [WORDS-1:0] wr_sel,
  input  logic [BITS-1:0]  wr_data,
  output logic [BITS-1:0]  sense_q,
  output logic             sense_vld,
  output logic             err_multi,
  output logic             err_conflict
);

  localparam logic [WORDS-1:0] ONE = {{(WORDS-1){1'b0}}, 1'b1};

  logic [WORDS-1:0][BITS-1:0] mem;
  logic [BITS-1:0]            picked;

  wire rd_any   = |rd_sel;
  wire wr_any   = |wr_sel;
  wire rd_multi = |(rd_sel & (rd_sel - ONE));
  wire conflict = rd_any & wr_any;
  wire do_clear = rd_any & clear_mode & ~wr_any;
  wire do_read  = rd_any & ~clear_mode & ~rd_multi & ~wr_any;
  wire bad_read = rd_any & ~clear_mode & rd_multi & ~wr_any;
  wire do_write = wr_any & ~rd_any;
  wire erase    = do_read | do_clear;

  always_comb begin
    picked = '0;
    for (int i = 0; i < WORDS; i++)
      if (rd_sel[i]) picked = picked | mem[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (erase && rd_sel[i])
          mem[i] <= '0;
        else if (do_write && wr_sel[i])
          mem[i] <= mem[i] | wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q      <= '0;
      sense_vld    <= 1'b0;
      err_multi    <= 1'b0;
      err_conflict <= 1'b0;
    end else begin
      sense_q      <= do_read ? picked : '0;
      sense_vld    <= do_read;
      err_multi    <= bad_read;
      err_conflict <= conflict;
    end
  end

endmodule

// File: rtl/wordline_store_chk.sv
module wordline_store_chk #(
  parameter int WORDS = 16,
  parameter int BITS  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WORDS-1:0] rd_sel,
  input logic             clear_mode,
  input logic [WORDS-1:0] wr_sel,
  input logic [BITS-1:0]  sense_q,
  input logic             sense_vld,
  input logic             err_multi,
  input logic             err_conflict
);

  AST_READ_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rd_sel) == 1 && !clear_mode && wr_sel == '0) |=> (sense_vld && !err_multi && !err_conflict)); // R2

  AST_CLEAR_NO_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel != '0 && clear_mode && wr_sel == '0) |=> (!sense_vld && sense_q == '0)); // R4

  AST_MULTI_READ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rd_sel) > 1 && !clear_mode && wr_sel == '0) |=> (err_multi && !sense_vld && sense_q == '0)); // R7

  AST_CONFLICT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel != '0 && wr_sel != '0) |=> (err_conflict && !sense_vld && sense_q == '0)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == '0 && wr_sel == '0) |=> (!sense_vld && !err_multi && !err_conflict && sense_q == '0)); // R9

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_multi && err_conflict)); // R10

endmodule

bind wordline_store wordline_store_chk #(.WORDS(WORDS), .BITS(BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .clear_mode(clear_mode),
  .wr_sel(wr_sel), .sense_q(sense_q), .sense_vld(sense_vld),
  .err_multi(err_multi), .err_conflict(err_conflict)
);

// File: tb/sim_wordline_store.sv
module sim_wordline_store;
  localparam int W = 4;
  localparam int B = 4;
  localparam int CLK_PERIOD = 10;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [W-1:0] rd_sel = '0;
  logic         clear_mode = 0;
  logic [W-1:0] wr_sel = '0;
  logic [B-1:0] wr_data = '0;
  logic [B-1:0] sense_q;
  logic         sense_vld, err_multi, err_conflict;

  int n_run = 0, n_fail = 0;
  logic [B-1:0] mdl [W];

  always #(CLK_PERIOD/2) clk = ~clk;

  wordline_store #(.WORDS(W), .BITS(B)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .clear_mode(clear_mode),
    .wr_sel(wr_sel), .wr_data(wr_data), .sense_q(sense_q), .sense_vld(sense_vld),
    .err_multi(err_multi), .err_conflict(err_conflict)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // apply one request at a negedge; outputs are sampled at the next negedge
  task automatic op(logic [W-1:0] r, logic c, logic [W-1:0] w, logic [B-1:0] d);
    @(negedge clk);
    rd_sel = r; clear_mode = c; wr_sel = w; wr_data = d;
    @(negedge clk);
    rd_sel = '0; clear_mode = 0; wr_sel = '0; wr_data = '0;
  endtask

  task automatic read_word(int i, logic [B-1:0] exp, string req);
    op(W'(1) << i, 1'b0, '0, '0);
    chk(req, int'(sense_q), int'(exp));
    chk(req, int'(sense_vld), 1);
    mdl[i] = '0;
  endtask

  task automatic clear_all();
    op('1, 1'b1, '0, '0);
    for (int i = 0; i < W; i++) mdl[i] = '0;
  endtask

  task automatic preload();
    clear_all();
    for (int i = 0; i < W; i++) begin
      op('0, 1'b0, W'(1) << i, B'(i + 3));
      mdl[i] = B'(i + 3);
    end
  endtask

  task automatic dump_check(string req);
    for (int i = 0; i < W; i++) read_word(i, mdl[i], req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < W; i++) mdl[i] = '0;
    #(CLK_PERIOD * 2 + 1);
    // R1 reset state
    chk("R1", int'(sense_q), 0);
    chk("R1", int'(sense_vld), 0);
    chk("R1", int'(err_multi), 0);
    chk("R1", int'(err_conflict), 0);
    rst_n = 1;
    dump_check("R1");

    // R2 R3: every value in every word, read twice
    for (int w = 0; w < W; w++)
      for (int v = 0; v < (1 << B); v++) begin
        op('0, 1'b0, W'(1) << w, B'(v));
        read_word(w, B'(v), "R2");
        read_word(w, '0, "R3");
      end

    // R5 R6: every write mask over a background
    for (int m = 1; m < (1 << W); m++) begin
      preload();
      op('0, 1'b0, W'(m), B'(m ^ 4'b1010));
      for (int i = 0; i < W; i++) if (m[i]) mdl[i] = mdl[i] | B'(m ^ 4'b1010);
      chk("R5", int'(err_multi | err_conflict | sense_vld), 0);
      dump_check("R5");
      op('0, 1'b0, W'(m), 4'b0101);
      op('0, 1'b0, W'(m), 4'b0010);
      for (int i = 0; i < W; i++) if (m[i]) mdl[i] = 4'b0111;
      dump_check("R6");
    end

    // R4: every clear mask
    for (int m = 1; m < (1 << W); m++) begin
      preload();
      op(W'(m), 1'b1, '0, '0);
      chk("R4", int'(sense_vld), 0);
      chk("R4", int'(sense_q), 0);
      chk("R10", int'(err_multi | err_conflict), 0);
      for (int i = 0; i < W; i++) if (m[i]) mdl[i] = '0;
      dump_check("R4");
    end

    // R7 R10: every multi-bit read mask
    for (int m = 1; m < (1 << W); m++) begin
      if ($countones(W'(m)) < 2) continue;
      preload();
      op(W'(m), 1'b0, '0, '0);
      chk("R7", int'(err_multi), 1);
      chk("R7", int'(sense_q), 0);
      chk("R7", int'(sense_vld), 0);
      chk("R10", int'(err_conflict), 0);
      op('0, 1'b0, '0, '0);
      chk("R10", int'(err_multi), 0);
      dump_check("R7");
    end

    // R8: conflicting masks, both modes
    for (int r = 1; r < (1 << W); r += 3)
      for (int w = 1; w < (1 << W); w += 5)
        for (int c = 0; c < 2; c++) begin
          preload();
          op(W'(r), c[0], W'(w), 4'b1111);
          chk("R8", int'(err_conflict), 1);
          chk("R8", int'(sense_vld), 0);
          chk("R8", int'(sense_q), 0);
          chk("R10", int'(err_multi), 0);
          dump_check("R8");
        end

    // R9: idle keeps storage and outputs quiet
    preload();
    op('0, 1'b1, '0, 4'b1111);
    chk("R9", int'(sense_vld | err_multi | err_conflict), 0);
    chk("R9", int'(sense_q), 0);
    dump_check("R9");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule